// File: doc/BRIEF.md
# Six-Channel DMA Priority Arbiter

This block decides which of six DMA channels may move data when several ask at once. Each cycle it forms the set of eligible channels: a channel is eligible when it requests, its own enable is set, the group enable is set, and no address error is pending. It then issues a registered one-hot grant. A granted channel keeps its grant for as long as it stays eligible. Only after that does the block choose again.

A two-bit mode field picks the arbitration policy. There are two fixed orders: plain ascending, and a second order that moves channel 1 down behind channels 2 and 3. The third policy is a rotating one in which the channel just served falls to the back of the line. The remaining code selects the ascending order.

A sticky address-error flag is set by any of three error-condition pulses: misaligned address, invalid space, or a target in stop state. While the flag is set it blocks every grant in the group. Software clears it with a read/write handshake: the flag must be read as 1, and a 0 must then be written to its bit. Mode and flag share one register, reached through a simple read strobe and write strobe.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `gnt` is a registered output that is all zero or one-hot. It reflects the eligibility seen on the previous clock edge.
- R2: A channel may be granted only if, at the preceding edge, its `req`, its `ch_en` bit and `glb_en` were all 1 and `addr_err` was 0.
- R3: Mode code 00 gives fixed priority with channel 0 highest, then 1, 2, 3, 4, 5. Code 10 behaves exactly like 00 but reads back as 10.
- R4: Mode code 01 gives fixed priority in the order 0, 2, 3, 1, 4, 5, highest first.
- R5: Mode code 11 gives round-robin priority. After reset channel 0 ranks highest. Each new grant made in this mode puts the granted channel last and the next channel up first. The rotation does not move in the other modes.
- R6: A granted channel keeps its grant while it stays eligible. Once it is no longer eligible, the next grant is chosen from the current eligible set on that same edge, or the grant becomes zero.
- R7: A 1 on `err_align`, `err_space` or `err_stop` at a clock edge sets `addr_err`. A set takes precedence over a clear in the same cycle.
- R8: While `addr_err` is 1, `gnt` is zero from the next edge on, whatever the enables are.
- R9: `addr_err` clears only on a write with bit 2 equal to 0. That write must follow a read strobe that saw the flag at 1, with no other write in between. A write with bit 2 equal to 1, or a write of 0 that no such read preceded, leaves the flag at 1.
- R10: The register reads the mode at bits 9:8 and the flag at bit 2, and all other bits read 0. A write loads bits 9:8 into the mode.
- R11: A synchronous reset clears the grant, the flag, the mode (to 00) and the clear handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NCH | Per-channel transfer request |
| ch_en | input | NCH | Per-channel enable |
| glb_en | input | 1 | Group enable |
| err_align | input | 1 | Misaligned address pulse |
| err_space | input | 1 | Invalid address space pulse |
| err_stop | input | 1 | Target in stop state pulse |
| csr_wr | input | 1 | Register write strobe |
| csr_rd | input | 1 | Register read strobe |
| csr_wdata | input | REG_W | Register write data |
| csr_rdata | output | REG_W | Register read data (combinational) |
| gnt | output | NCH | One-hot grant |
| addr_err | output | 1 | Sticky address-error flag |

## Verification
The bench builds the block with its defaults: six channels and a 16-bit register. Six channels is the count at which the second fixed order is fully defined, and at which the round-robin wrap from channel 5 back to 0 comes up often in random traffic. A 16-bit register makes the mode field at bits 9:8 and the all-zero upper bits visible on read-back. With these values, random request patterns in all four mode codes reach the hold-then-rearbitrate edge, the wrap of the rotation, and the interaction of the error handshake with reads and writes issued in the same cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    typedef enum logic [1:0] {
        MODE_ASC = 2'b00,
        MODE_ALT = 2'b01,
        MODE_RSV = 2'b10,
        MODE_RR  = 2'b11
    } arb_mode_e;

    localparam int MODE_LSB = 8;
    localparam int FLAG_BIT = 2;

    typedef struct packed {
        arb_mode_e mode;
        logic      flag;
        logic      armed;
    } csr_state_t;

    // Priority position of a channel: 0 is served first.
    function automatic int unsigned chan_rank(arb_mode_e m, int unsigned ch,
                                              int unsigned ptr, int unsigned n);
        int unsigned r;
        case (m)
            MODE_ALT: begin
                if (ch == 1)      r = 3;
                else if (ch == 2) r = 1;
                else if (ch == 3) r = 2;
                else              r = ch;
            end
            MODE_RR:  r = (ch + n - ptr) % n;
            default:  r = ch;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dma_arb_csr.sv
module dma_arb_csr
    import dma_arb_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_wr,
    input  logic             csr_rd,
    input  logic [REG_W-1:0] csr_wdata,
    input  logic             err_any,
    output logic [REG_W-1:0] csr_rdata,
    output arb_mode_e        mode,
    output logic             flag
);

    csr_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (csr_wr)
            st_d.mode = arb_mode_e'(csr_wdata[MODE_LSB +: 2]);
        if (err_any)
            st_d.flag = 1'b1;
        else if (csr_wr && st_q.armed && !csr_wdata[FLAG_BIT])
            st_d.flag = 1'b0;
        if (csr_wr)
            st_d.armed = 1'b0;
        else if (csr_rd && st_q.flag)
            st_d.armed = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: MODE_ASC, flag: 1'b0, armed: 1'b0};
        else     st_q <= st_d;
    end

    always_comb begin
        csr_rdata = '0;
        csr_rdata[MODE_LSB +: 2] = st_q.mode;
        csr_rdata[FLAG_BIT]      = st_q.flag;
    end

    assign mode = st_q.mode;
    assign flag = st_q.flag;

    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst)
        err_any |=> flag); // R7

    AST_W1_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_wdata[FLAG_BIT] && flag) |=> flag); // R9

    AST_CLR_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        $fell(flag) |-> $past(csr_wr && st_q.armed && !csr_wdata[FLAG_BIT])); // R9

endmodule

// File: rtl/dma_arb_select.sv
module dma_arb_select
    import dma_arb_pkg::*;
#(
    parameter int NCH = 6,
    parameter int CW  = $clog2(NCH)
) (
    input  arb_mode_e        mode,
    input  logic [CW-1:0]    ptr,
    input  logic [NCH-1:0]   elig,
    output logic [NCH-1:0]   pick,
    output logic [CW-1:0]    pick_idx,
    output logic             pick_vld
);

    always_comb begin
        int unsigned best;
        int unsigned r;
        best     = NCH;
        pick_idx = '0;
        for (int c = 0; c < NCH; c++) begin
            r = chan_rank(mode, c, int'(ptr), NCH);
            if (elig[c] && r < best) begin
                best     = r;
                pick_idx = CW'(c);
            end
        end
        pick_vld = |elig;
        pick     = '0;
        if (pick_vld) pick[pick_idx] = 1'b1;
    end

endmodule

// File: rtl/dma_arb_rr_ptr.sv
module dma_arb_rr_ptr #(
    parameter int NCH = 6,
    parameter int CW  = $clog2(NCH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    input  logic [CW-1:0] win_idx,
    output logic [CW-1:0] ptr
);

    localparam logic [CW-1:0] LAST = CW'(NCH - 1);

    always_ff @(posedge clk) begin
        if (rst)      ptr <= '0;
        else if (adv) ptr <= (win_idx == LAST) ? '0 : win_idx + 1'b1;
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NCH   = 6,
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   req,
    input  logic [NCH-1:0]   ch_en,
    input  logic             glb_en,
    input  logic             err_align,
    input  logic             err_space,
    input  logic             err_stop,
    input  logic             csr_wr,
    input  logic             csr_rd,
    input  logic [REG_W-1:0] csr_wdata,
    output logic [REG_W-1:0] csr_rdata,
    output logic [NCH-1:0]   gnt,
    output logic             addr_err
);

    localparam int CW = $clog2(NCH);

    arb_mode_e      mode;
    logic           flag;
    logic [NCH-1:0] elig;
    logic [NCH-1:0] pick;
    logic [CW-1:0]  pick_idx;
    logic           pick_vld;
    logic [CW-1:0]  ptr;
    logic [NCH-1:0] gnt_q, gnt_d;
    logic           held;
    logic           new_grant;

    dma_arb_csr #(.REG_W(REG_W)) u_csr (
        .clk       (clk),
        .rst       (rst),
        .csr_wr    (csr_wr),
        .csr_rd    (csr_rd),
        .csr_wdata (csr_wdata),
        .err_any   (err_align | err_space | err_stop),
        .csr_rdata (csr_rdata),
        .mode      (mode),
        .flag      (flag)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_elig
        assign elig[g] = req[g] & ch_en[g] & glb_en & ~flag;
    end

    dma_arb_select #(.NCH(NCH), .CW(CW)) u_sel (
        .mode     (mode),
        .ptr      (ptr),
        .elig     (elig),
        .pick     (pick),
        .pick_idx (pick_idx),
        .pick_vld (pick_vld)
    );

    assign held      = |(gnt_q & elig);
    assign new_grant = !held && pick_vld;
    assign gnt_d     = held ? gnt_q : pick;

    dma_arb_rr_ptr #(.NCH(NCH), .CW(CW)) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .adv     (new_grant && mode == MODE_RR),
        .win_idx (pick_idx),
        .ptr     (ptr)
    );

    always_ff @(posedge clk) begin
        if (rst) gnt_q <= '0;
        else     gnt_q <= gnt_d;
    end

    assign gnt      = gnt_q;
    assign addr_err = flag;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_q)); // R1

    AST_GNT_ELIG: assert property (@(posedge clk) disable iff (rst)
        (|gnt_q) |-> (|(gnt_q & $past(req & ch_en & {NCH{glb_en}})))); // R2

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        flag |=> (gnt_q == '0)); // R8

    AST_GNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (|(gnt_q & req & ch_en) && glb_en && !flag) |=> $stable(gnt_q)); // R6

endmodule

// File: tb/test_dma_prio_arbiter.sv
module test_dma_prio_arbiter;

    localparam int N = 6;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] req, ch_en;
    logic         glb_en, err_align, err_space, err_stop;
    logic         csr_wr, csr_rd;
    logic [W-1:0] csr_wdata;
    logic [W-1:0] csr_rdata;
    logic [N-1:0] gnt;
    logic         addr_err;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dma_prio_arbiter #(.NCH(N), .REG_W(W)) i_dma_prio_arbiter (
        .clk(clk), .rst(rst), .req(req), .ch_en(ch_en), .glb_en(glb_en),
        .err_align(err_align), .err_space(err_space), .err_stop(err_stop),
        .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .gnt(gnt), .addr_err(addr_err)
    );

    // Behavioural reference
    int m_mode, m_flag, m_arm, m_gnt, m_ptr;
    int ord_asc [N] = '{0, 1, 2, 3, 4, 5};
    int ord_alt [N] = '{0, 2, 3, 1, 4, 5};

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_flag = 0; m_arm = 0; m_gnt = -1; m_ptr = 0;
        end else begin
            bit e [N];
            int nf;
            for (int c = 0; c < N; c++)
                e[c] = req[c] && ch_en[c] && glb_en && (m_flag == 0);
            if (!(m_gnt >= 0 && e[m_gnt])) begin
                int nw;
                nw = -1;
                for (int k = 0; k < N; k++) begin
                    int ch;
                    if (m_mode == 3)      ch = (m_ptr + k) % N;
                    else if (m_mode == 1) ch = ord_alt[k];
                    else                  ch = ord_asc[k];
                    if (nw < 0 && e[ch]) nw = ch;
                end
                m_gnt = nw;
                if (nw >= 0 && m_mode == 3) m_ptr = (nw + 1) % N;
            end
            if (err_align || err_space || err_stop)            nf = 1;
            else if (csr_wr && m_arm == 1 && !csr_wdata[2])     nf = 0;
            else                                               nf = m_flag;
            if (csr_wr)                       m_arm = 0;
            else if (csr_rd && m_flag == 1)   m_arm = 1;
            if (csr_wr) m_mode = int'(csr_wdata[9:8]);
            m_flag = nf;
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            logic [N-1:0] eg;
            string tg;
            eg = (m_gnt >= 0) ? N'(1 << m_gnt) : '0;
            tg = (m_mode == 1) ? "R4 grant" : (m_mode == 3) ? "R5 grant" : "R3 grant";
            check(tg, 32'(gnt), 32'(eg));
            check("R7 flag", 32'(addr_err), 32'(m_flag));
            check("R10 readback", 32'(csr_rdata), 32'((m_mode << 8) | (m_flag << 2)));
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [W-1:0] d);
        csr_wr = 1'b1; csr_wdata = d;
        cyc();
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic rd();
        csr_rd = 1'b1;
        cyc();
        csr_rd = 1'b0;
    endtask

    task automatic random_run(int md, int cycles);
        wr(W'(md << 8));
        for (int i = 0; i < cycles; i++) begin
            if ($urandom_range(0, 2) == 0) req[$urandom_range(0, N - 1)] ^= 1'b1;
            ch_en  = ($urandom_range(0, 7) == 0) ? N'($urandom) : '1;
            glb_en = ($urandom_range(0, 15) != 0);
            cyc();
        end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; req = '0; ch_en = '0; glb_en = 1'b0;
        err_align = 1'b0; err_space = 1'b0; err_stop = 1'b0;
        csr_wr = 1'b0; csr_rd = 1'b0; csr_wdata = '0;
        repeat (3) cyc();
        check("R11 reset gnt", 32'(gnt), 0);
        check("R11 reset flag", 32'(addr_err), 0);
        check("R11 reset reg", 32'(csr_rdata), 0);
        rst = 1'b0;
        cyc();

        // R3: all request in ascending mode, channel 0 wins
        ch_en = '1; glb_en = 1'b1; req = 6'b111111;
        cyc();
        check("R3 first winner", 32'(gnt), 32'h01);
        // R6: hold then move on when the holder drops
        req = 6'b111110;
        cyc();
        check("R6 next after drop", 32'(gnt), 32'h02);
        req = 6'b111100; cyc();
        req = '0; cyc();

        // R4: channel 1 loses to 2 and 3
        wr(16'h0100);
        req = 6'b001110; cyc();
        check("R4 alt order", 32'(gnt), 32'h04);
        req = 6'b001010; cyc();
        check("R4 alt order 3 over 1", 32'(gnt), 32'h08);
        req = '0; cyc();

        // R2: group enable and channel enable gate the grant
        glb_en = 1'b0; req = '1; cyc();
        check("R2 group enable off", 32'(gnt), 0);
        glb_en = 1'b1; ch_en = 6'b100000; cyc();
        check("R2 only enabled channel", 32'(gnt), 32'h20);
        ch_en = '1; req = '0; cyc();

        // R5: round-robin from reset pointer
        wr(16'h0300);
        req = 6'b000101; cyc();
        check("R5 rr first", 32'(gnt), 32'h01);
        req = 6'b000100; cyc(); req = 6'b000101; cyc();
        check("R5 rr rotates", 32'(gnt), 32'h04);
        req = '0; cyc();

        // R7 / R8 / R9: error handshake
        req = '1;
        err_align = 1'b1; cyc(); err_align = 1'b0;
        check("R7 align sets", 32'(addr_err), 1);
        cyc();
        check("R8 blocked", 32'(gnt), 0);
        wr(16'h0304);
        check("R9 write one keeps", 32'(addr_err), 1);
        wr(16'h0300);
        check("R9 write zero unread keeps", 32'(addr_err), 1);
        rd(); wr(16'h0300);
        check("R9 read then clear", 32'(addr_err), 0);
        err_space = 1'b1; cyc(); err_space = 1'b0;
        rd();
        csr_wr = 1'b1; csr_wdata = 16'h0300; err_stop = 1'b1;
        cyc();
        csr_wr = 1'b0; err_stop = 1'b0;
        check("R7 set beats clear", 32'(addr_err), 1);
        rd(); wr(16'h0300);
        check("R9 clear again", 32'(addr_err), 0);
        req = '0; cyc();

        random_run(0, 300);
        random_run(1, 300);
        random_run(3, 400);
        random_run(2, 300);
        random_run(3, 200);
        wr(16'h0200);
        check("R10 reserved mode reads back", 32'(csr_rdata), 32'h0200);

        cyc();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule